// File: doc/BRIEF.md
# DMA page and address generator

This block forms the physical byte address presented to memory on each step of a DMA transfer. There are eight channels. Channels 0 to 3 move bytes and channels 4 to 7 move 16-bit words. Each channel has an 8-bit page register, written through page I/O ports. Each transfer is set up with a starting offset and a unit count. The block joins the channel's page to the current 16-bit offset to form the address.

On a word channel the offset counts words, so it is shifted left by one to become a byte address. In that case bit 0 of the page is dropped, which gives a 128 KiB window. On every step the offset is incremented and then ANDed with a wrap mask. The offset therefore wraps inside its window and never carries into the page. A transfer moves count+1 units, and a one-cycle terminal-count pulse marks its end.

Top module: `dma_addr_gen`

## Requirements
- R1: A page write to port 0x81 loads channel 2, 0x82 loads channel 3 and 0x83 loads channel 1.
- R2: A page write to port 0x89 loads channel 6, 0x8A loads channel 7 and 0x8B loads channel 5.
- R3: A page write to any other port has no effect. Channels 0 and 4 keep page 0 at all times.
- R4: Only bits [7:0] of `pg_data` are stored as the page.
- R5: On channels 0-3, `byte_addr` = {page[7:0], offset[15:0]}.
- R6: On channels 4-7, `byte_addr` = {page[7:1], offset[15:0], 1'b0}.
- R7: Each accepted step sets the offset to (offset+1) & `wrap_mask`. The page bits of `byte_addr` do not change.
- R8: `start` loads the offset as `start_ofs` & `wrap_mask`.
- R9: A transfer accepts `start_cnt`+1 steps. The step taken when the count is 0 clears `busy` and raises `tc` for exactly one cycle. `xfer_bytes` = (`start_cnt`+1), shifted left by one on channels 4-7.
- R10: A `step` while `busy` is low has no effect on any output.
- R11: After reset, `busy`, `tc`, `xfer_bytes`, `byte_addr` and all page registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pg_wr | input | 1 | Page port write strobe |
| pg_port | input | 8 | Page port I/O address (low byte) |
| pg_data | input | 16 | Page write data; only the low byte is used |
| start | input | 1 | Begin a transfer |
| start_ch | input | 3 | Channel of the new transfer |
| start_ofs | input | 16 | Starting offset, in units |
| start_cnt | input | 16 | Unit count minus one |
| wrap_mask | input | 16 | Offset wrap mask |
| step | input | 1 | Advance one unit |
| byte_addr | output | 24 | Physical byte address of the current unit |
| xfer_bytes | output | 18 | Transfer length in bytes |
| busy | output | 1 | Transfer in progress |
| tc | output | 1 | Terminal-count pulse |

## Verification
A wrong port decode sends a page to the wrong channel. The bench sees this on the next transfer started on that channel, because the upper address bits come out wrong in the first cycle after `start`. A stuck offset or a wrong wrap shows up in `byte_addr` one cycle after the faulty step, as a carry into the page bits or a lost wrap. A wrong count shows up as `tc` arriving one or more steps early or late, and as `busy` staying high.

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int PW = 8,
  parameter int OW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pg_wr,
  input  logic [7:0]         pg_port,
  input  logic [15:0]        pg_data,
  input  logic               start,
  input  logic [2:0]         start_ch,
  input  logic [OW-1:0]      start_ofs,
  input  logic [OW-1:0]      start_cnt,
  input  logic [OW-1:0]      wrap_mask,
  input  logic               step,
  output logic [PW+OW-1:0]   byte_addr,
  output logic [OW+1:0]      xfer_bytes,
  output logic               busy,
  output logic               tc
);
  localparam int AW = PW + OW;

  logic [PW-1:0] page_q [8];
  logic          hit;
  logic [2:0]    idx;
  logic [2:0]    ch_q;
  logic [OW-1:0] ofs_q, cnt_q;
  logic [PW-1:0] page_cur;

  always_comb begin
    hit = 1'b1;
    idx = 3'd0;
    case (pg_port)
      8'h81: idx = 3'd2;
      8'h82: idx = 3'd3;
      8'h83: idx = 3'd1;
      8'h89: idx = 3'd6;
      8'h8A: idx = 3'd7;
      8'h8B: idx = 3'd5;
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) page_q[i] <= '0;
    end else if (pg_wr && hit) begin
      page_q[idx] <= pg_data[PW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_q       <= '0;
      ofs_q      <= '0;
      cnt_q      <= '0;
      busy       <= 1'b0;
      tc         <= 1'b0;
      xfer_bytes <= '0;
    end else begin
      tc <= 1'b0;
      if (start) begin
        ch_q       <= start_ch;
        ofs_q      <= start_ofs & wrap_mask;
        cnt_q      <= start_cnt;
        busy       <= 1'b1;
        xfer_bytes <= ({2'b00, start_cnt} + 1'b1) << start_ch[2];
      end else if (step && busy) begin
        ofs_q <= (ofs_q + 1'b1) & wrap_mask;
        if (cnt_q == '0) begin
          busy <= 1'b0;
          tc   <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign page_cur  = page_q[ch_q];
  assign byte_addr = ch_q[2] ? AW'({page_cur[PW-1:1], ofs_q, 1'b0})
                             : AW'({page_cur, ofs_q});
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
  parameter int PW = 8,
  parameter int OW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pg_wr,
  input logic             start,
  input logic             step,
  input logic [PW+OW-1:0] byte_addr,
  input logic             busy,
  input logic             tc
);
  assert_tc_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);
  assert_tc_ends_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> !busy);
  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !tc));
  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && !pg_wr) |=> $stable(byte_addr));
  assert_page_no_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step && !start && !pg_wr) |=> $stable(byte_addr[PW+OW-1:OW+1]));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.PW(PW), .OW(OW)) chk_i (
  .clk(clk), .rst_n(rst_n), .pg_wr(pg_wr), .start(start), .step(step),
  .byte_addr(byte_addr), .busy(busy), .tc(tc));

// File: tb/dma_addr_gen_tb_top.sv
module dma_addr_gen_tb_top;
  logic clk = 0, rst_n = 0;
  logic pg_wr = 0, start = 0, step = 0;
  logic [7:0] pg_port = 0;
  logic [15:0] pg_data = 0, start_ofs = 0, start_cnt = 0, wrap_mask = 16'hFFFF;
  logic [2:0] start_ch = 0;
  logic [23:0] byte_addr;
  logic [17:0] xfer_bytes;
  logic busy, tc;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  dma_addr_gen dut_i (.clk(clk), .rst_n(rst_n), .pg_wr(pg_wr), .pg_port(pg_port),
    .pg_data(pg_data), .start(start), .start_ch(start_ch), .start_ofs(start_ofs),
    .start_cnt(start_cnt), .wrap_mask(wrap_mask), .step(step),
    .byte_addr(byte_addr), .xfer_bytes(xfer_bytes), .busy(busy), .tc(tc));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_page(logic [7:0] port, logic [15:0] d);
    pg_wr = 1; pg_port = port; pg_data = d;
    @(negedge clk); pg_wr = 0;
  endtask

  task automatic go(logic [2:0] ch, logic [15:0] ofs, logic [15:0] cnt);
    start = 1; start_ch = ch; start_ofs = ofs; start_cnt = cnt;
    @(negedge clk); start = 0;
  endtask

  task automatic one_step();
    step = 1; @(negedge clk); step = 0;
  endtask

  function automatic logic [23:0] exp_addr(logic [2:0] ch, logic [7:0] pg, logic [15:0] o);
    return ch[2] ? {pg[7:1], o, 1'b0} : {pg, o};
  endfunction

  task automatic t_reset();
    chk("R11 busy", busy, 0); chk("R11 tc", tc, 0);
    chk("R11 xfer", xfer_bytes, 0); chk("R11 addr", byte_addr, 0);
  endtask

  task automatic t_low_ports();
    wr_page(8'h81, 16'h12A5); wr_page(8'h82, 16'h003C); wr_page(8'h83, 16'hFF71);
    go(3'd2, 16'h1234, 0); chk("R1 R4 R5 ch2", byte_addr, exp_addr(2, 8'hA5, 16'h1234));
    go(3'd3, 16'h0001, 0); chk("R1 ch3", byte_addr, exp_addr(3, 8'h3C, 16'h0001));
    go(3'd1, 16'hBEEF, 0); chk("R1 R4 ch1", byte_addr, exp_addr(1, 8'h71, 16'hBEEF));
  endtask

  task automatic t_high_ports();
    wr_page(8'h89, 16'h0037); wr_page(8'h8A, 16'h0052); wr_page(8'h8B, 16'h00E9);
    go(3'd6, 16'h8001, 0); chk("R2 R6 ch6", byte_addr, exp_addr(6, 8'h37, 16'h8001));
    go(3'd7, 16'hFFFF, 0); chk("R2 R6 ch7", byte_addr, exp_addr(7, 8'h52, 16'hFFFF));
    go(3'd5, 16'h0100, 0); chk("R2 R6 ch5", byte_addr, exp_addr(5, 8'hE9, 16'h0100));
  endtask

  task automatic t_unmapped();
    wr_page(8'h80, 16'h00AA); wr_page(8'h87, 16'h00BB);
    wr_page(8'h8F, 16'h00CC); wr_page(8'h88, 16'h00DD);
    go(3'd0, 16'h4321, 0); chk("R3 ch0", byte_addr, exp_addr(0, 8'h00, 16'h4321));
    go(3'd4, 16'h4321, 0); chk("R3 ch4", byte_addr, exp_addr(4, 8'h00, 16'h4321));
    go(3'd2, 16'h0000, 0); chk("R3 ch2 kept", byte_addr, exp_addr(2, 8'hA5, 16'h0000));
  endtask

  task automatic t_wrap();
    logic [15:0] o;
    wr_page(8'h83, 16'h0044);
    wrap_mask = 16'h00FF;
    go(3'd1, 16'h12FE, 3);
    o = 16'h12FE & 16'h00FF;
    chk("R8 masked start", byte_addr, exp_addr(1, 8'h44, o));
    for (int i = 0; i < 3; i++) begin
      one_step(); o = (o + 1) & 16'h00FF;
      chk("R7 wrap step", byte_addr, exp_addr(1, 8'h44, o));
    end
    wrap_mask = 16'hFFFF;
    go(3'd1, 16'hFFFF, 1); one_step();
    chk("R7 no carry byte", byte_addr, exp_addr(1, 8'h44, 16'h0000));
    go(3'd6, 16'hFFFF, 1); one_step();
    chk("R7 R6 no carry word", byte_addr, exp_addr(6, 8'h37, 16'h0000));
  endtask

  task automatic t_count();
    go(3'd2, 16'h0010, 3);
    chk("R9 xfer byte", xfer_bytes, 4); chk("R9 busy", busy, 1);
    for (int i = 0; i < 3; i++) begin
      one_step(); chk("R9 no early tc", tc, 0); chk("R9 still busy", busy, 1);
    end
    one_step();
    chk("R9 tc", tc, 1); chk("R9 idle", busy, 0);
    @(negedge clk); chk("R9 tc one cycle", tc, 0);
    chk("R10 pre", byte_addr, exp_addr(2, 8'hA5, 16'h0014));
    one_step(); one_step();
    chk("R10 idle step addr", byte_addr, exp_addr(2, 8'hA5, 16'h0014));
    chk("R10 idle step tc", tc, 0); chk("R10 idle busy", busy, 0);
    go(3'd5, 16'h0000, 3); chk("R9 xfer word", xfer_bytes, 8);
    go(3'd0, 16'h0000, 16'hFFFF); chk("R9 xfer max", xfer_bytes, 18'h10000);
  endtask

  initial begin
    #100000;
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_low_ports();
    t_high_ports();
    t_unmapped();
    t_wrap();
    t_count();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule